// File: doc/BRIEF.md
# Claim/Complete Interrupt Controller

This block gathers interrupt requests from a parameterised set of sources and routes them to several processor contexts. Every source has a small priority value and a gateway that turns its input into a single pending request, either by sampling a high level or by catching a rising edge. Every context has its own enable vector and priority threshold, and it receives one level interrupt line. That line is high while at least one pending source is enabled for the context and has a priority strictly above the context's threshold.

Software services an interrupt in two steps. It first reads the context's claim/complete register. The read returns the identity of the best eligible source and removes that source's pending request in the same access. Once the handler is done, software writes the same identity back to that register. Between claim and completion the source's gateway is closed, so it takes no new request. Identity 0 means "no source": a claim that returns 0 found nothing to serve.

Access uses a plain 32-bit read/write bus addressed in bytes, one word per register. Read data is registered and appears the cycle after the read strobe. Source identities run from 1 to `NSRC`. Input bit k of `src_irq` belongs to source k+1. The parameter `EDGE_SRC` selects the rising-edge sources by the same bit numbering.

Top module: `intc_claim`

## Requirements
- R1: After reset every priority, enable bit and threshold reads as 0, nothing is pending, every `irq_o` bit is low, and every claim read returns 0.
- R2: The priority of source N sits at byte address 4*N, holds 3 bits (write data bits 2:0) and reads back zero-extended; the word at address 0 (source 0) always reads 0 and ignores writes.
- R3: The enable word for context c sits at 0x2000 + c*0x80; bit N of that word enables source N for context c, and bit 0 always reads 0.
- R4: A source can raise `irq_o[c]` only when it is pending, enabled for c and its priority is strictly greater than the threshold of c (at 0x200000 + c*0x1000, bits 2:0). A threshold of 7 blocks every source, and a priority of 0 never interrupts.
- R5: When several sources are eligible for a context, the claim picks the highest priority, and among equal priorities the lowest source number.
- R6: A read at 0x200004 + c*0x1000 returns the winning source number on `bus_rdata` in the next cycle, clears that source's pending bit and closes its gateway. It returns 0 when nothing is eligible. `irq_o[c]` falls in the cycle after the claim that takes the last eligible source.
- R7: Writing source number N to a context's claim/complete register reopens N's gateway only if N is enabled for that context. Writes of a number that is not enabled, of 0, or of a number above `NSRC` change nothing.
- R8: A level source becomes pending whenever its input is high and its gateway is open. If the input is still high when the completion arrives, the source pends again at once. While the source is claimed, no new request is taken.
- R9: An edge source becomes pending once per rising edge of its input. A level held high after completion does not pend again, and a rising edge that arrives while the source is pending or claimed is dropped.
- R10: A rising edge that arrives in the same cycle as the completion write for that source is taken as a new pending request.
- R11: Each context has its own enable vector and threshold. A claim made by one context also removes the source from every other context's eligible set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NSRC | Request inputs; bit k belongs to source k+1 |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | NCTX | Level interrupt, one per context |

## Verification
A completion write and a new request from the same source's input can land in the same cycle. This happens when a level input is still high, or when an edge source rises exactly as its completion is written. The gateway must accept the request in that cycle and not lose it to the source's closed state. The bench provokes the edge case directly: it holds the input low while the source is claimed, then raises the input in the cycle of the completion write, and it judges the outcome by the next claim returning that source number. The random phase also lands input toggles on claim and completion cycles. It compares every read value and every `irq_o` bit with a cycle-level model in the bench, which also covers the opposite collision, an edge in the very cycle of a claim, which must be dropped.

// File: rtl/intc_claim.sv
`timescale 1ns/1ps
module intc_claim #(
  parameter int NSRC = 31,
  parameter int NCTX = 2,
  parameter int PW = 3,
  parameter int ADDR_W = 24,
  parameter logic [NSRC-1:0] EDGE_SRC = {{(NSRC/2){1'b1}}, {(NSRC-NSRC/2){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_irq,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_o
);
  localparam int IDW = $clog2(NSRC + 1);
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int NW  = (NSRC + 32) / 32;
  localparam logic [31:0] EN_BASE = 32'h0000_2000;
  localparam logic [31:0] CX_BASE = 32'h0020_0000;

  logic [PW-1:0]  prio_q [NSRC+1];
  logic [NSRC:0]  en_q   [NCTX];
  logic [PW-1:0]  thr_q  [NCTX];
  logic [NSRC:0]  pend_q, busy_q, prev_q;
  logic [NSRC:0]  pend_d, busy_d, in_v, edge_v, req_v;
  logic [NSRC:0]  clm_vec, cmp_vec;
  logic [IDW-1:0] best_id [NCTX];
  logic [PW-1:0]  best_p  [NCTX];

  logic [31:0] a, en_off, cx_off, rd_val, en_rd;
  logic        rd, wr, hit_prio, hit_en, hit_cx, is_thr, is_clm;
  logic [CW-1:0]  en_ctx, cx_ctx;
  logic [IDW-1:0] pid, cid, clm_id;
  logic           clm_go, cmp_ok;

  // address decode
  assign a        = 32'(bus_addr) & ~32'd3;
  assign en_off   = a - EN_BASE;
  assign cx_off   = a - CX_BASE;
  assign rd       = bus_en & ~bus_we;
  assign wr       = bus_en & bus_we;
  assign hit_prio = a < 32'(4 * (NSRC + 1));
  assign hit_en   = (a >= EN_BASE) && (en_off < 32'(NCTX * 128))
                    && ({27'd0, en_off[6:2]} < 32'(NW));
  assign hit_cx   = (a >= CX_BASE) && (cx_off < 32'(NCTX * 4096));
  assign is_thr   = hit_cx && (cx_off[11:0] == 12'h000);
  assign is_clm   = hit_cx && (cx_off[11:0] == 12'h004);
  assign en_ctx   = CW'(en_off >> 7);
  assign cx_ctx   = CW'(cx_off >> 12);
  assign pid      = a[IDW+1:2];
  assign cid      = bus_wdata[IDW-1:0];

  // per-context arbitration: strict compare keeps the lowest ID on ties
  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      best_id[c] = '0;
      best_p[c]  = '0;
      for (int s = 1; s <= NSRC; s++) begin
        if (pend_q[s] && en_q[c][s] && (prio_q[s] > thr_q[c]) && (prio_q[s] > best_p[c])) begin
          best_p[c]  = prio_q[s];
          best_id[c] = IDW'(s);
        end
      end
      irq_o[c] = (best_id[c] != '0);
    end
  end

  // claim and complete
  assign clm_id  = best_id[cx_ctx];
  assign clm_go  = rd && is_clm && (clm_id != '0);
  assign cmp_ok  = wr && is_clm && (bus_wdata != 32'd0) && (bus_wdata <= 32'(NSRC))
                   && en_q[cx_ctx][cid];
  assign clm_vec = clm_go ? ((NSRC+1)'(1) << clm_id) : '0;
  assign cmp_vec = cmp_ok ? ((NSRC+1)'(1) << cid) : '0;

  // gateways
  assign in_v   = {src_irq, 1'b0};
  assign edge_v = {EDGE_SRC, 1'b0};
  assign req_v  = (edge_v & in_v & ~prev_q) | (~edge_v & in_v);
  assign pend_d = (pend_q & ~clm_vec) | (req_v & ~pend_q & (~busy_q | cmp_vec));
  assign busy_d = (busy_q & ~cmp_vec) | clm_vec;

  // read mux
  always_comb begin
    en_rd = '0;
    for (int s = 1; s <= NSRC; s++)
      if ((s / 32) == int'(en_off[6:2])) en_rd[s % 32] = en_q[en_ctx][s];
  end

  always_comb begin
    rd_val = '0;
    if (hit_prio)    rd_val = 32'(prio_q[pid]);
    else if (hit_en) rd_val = en_rd;
    else if (is_thr) rd_val = 32'(thr_q[cx_ctx]);
    else if (is_clm) rd_val = 32'(clm_id);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      busy_q    <= '0;
      prev_q    <= '0;
      bus_rdata <= '0;
      for (int s = 0; s <= NSRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      prev_q <= in_v;
      if (rd) bus_rdata <= rd_val;
      if (wr) begin
        if (hit_prio && pid != '0) prio_q[pid] <= bus_wdata[PW-1:0];
        if (hit_en)
          for (int s = 1; s <= NSRC; s++)
            if ((s / 32) == int'(en_off[6:2])) en_q[en_ctx][s] <= bus_wdata[s % 32];
        if (is_thr) thr_q[cx_ctx] <= bus_wdata[PW-1:0];
      end
    end
  end

  AST_PEND_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & busy_q) == '0); // R8
  AST_CLAIM_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && is_clm) |=> (bus_rdata == 32'($past(clm_id)))); // R6
  AST_CLAIM_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    clm_go |=> ((busy_q & $past(clm_vec)) == $past(clm_vec))); // R6
  AST_CMPL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_ok |=> ((busy_q & $past(cmp_vec)) == '0)); // R7

  for (genvar c = 0; c < NCTX; c++) begin : g_thr_chk
    AST_THR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q[c] == '1) |-> !irq_o[c]); // R4
  end
endmodule

// File: tb/intc_claim_tb.sv
`timescale 1ns/1ps
module intc_claim_tb;
  localparam int NSRC = 31;
  localparam int NCTX = 2;
  localparam logic [NSRC-1:0] EDGE = {{15{1'b1}}, {16{1'b0}}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_irq = '0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCTX-1:0] irq_o;

  always #2 clk = ~clk;

  intc_claim #(.NSRC(NSRC), .NCTX(NCTX), .PW(3), .ADDR_W(24), .EDGE_SRC(EDGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o));

  int n_chk = 0, n_fail = 0;
  int m_prio [0:NSRC];
  bit m_en   [0:NCTX-1][0:NSRC];
  int m_thr  [0:NCTX-1];
  bit m_pend [0:NSRC];
  bit m_busy [0:NSRC];
  bit m_prev [0:NSRC];
  bit s_in   [0:NSRC];
  int m_last [0:NCTX-1];

  function automatic logic [23:0] pa(int id); return 24'(4 * id); endfunction
  function automatic logic [23:0] ea(int c);  return 24'(32'h2000 + c * 32'h80); endfunction
  function automatic logic [23:0] ta(int c);  return 24'(32'h200000 + c * 32'h1000); endfunction
  function automatic logic [23:0] ca(int c);  return 24'(32'h200004 + c * 32'h1000); endfunction

  function automatic int win(int c);
    int bp = 0, bi = 0;
    for (int s = 1; s <= NSRC; s++)
      if (m_pend[s] && m_en[c][s] && m_prio[s] > m_thr[c] && m_prio[s] > bp) begin
        bp = m_prio[s]; bi = s;
      end
    return bi;
  endfunction

  // 1 priority, 2 enable word, 3 threshold, 4 claim/complete, 0 nothing
  function automatic int kind(logic [23:0] a);
    int x = int'(a);
    if (x < 128) return 1;
    if (x >= 32'h2000 && x < 32'h2000 + NCTX * 32'h80 && ((x - 32'h2000) % 32'h80) == 0) return 2;
    if (x >= 32'h200000 && x < 32'h200000 + NCTX * 32'h1000) begin
      if (((x - 32'h200000) % 32'h1000) == 0) return 3;
      if (((x - 32'h200000) % 32'h1000) == 4) return 4;
    end
    return 0;
  endfunction

  function automatic int actx(logic [23:0] a);
    int x = int'(a);
    if (x >= 32'h200000) return (x - 32'h200000) / 32'h1000;
    if (x >= 32'h2000) return (x - 32'h2000) / 32'h80;
    return 0;
  endfunction

  function automatic logic [31:0] rd_exp(logic [23:0] a);
    logic [31:0] v = '0;
    int c = actx(a);
    case (kind(a))
      1: v = 32'(m_prio[int'(a) / 4]);
      2: for (int s = 1; s <= NSRC; s++) v[s] = m_en[c][s];
      3: v = 32'(m_thr[c]);
      4: v = 32'(win(c));
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, advance the model, check after the edge
  task automatic cyc(input bit en, input bit we, input logic [23:0] a, input logic [31:0] d, input string tag);
    int k, c, w;
    bit clm [0:NSRC];
    bit cmp [0:NSRC];
    bit np  [0:NSRC];
    bit nb  [0:NSRC];
    bit req;
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
    for (int s = 1; s <= NSRC; s++) src_irq[s-1] = s_in[s];
    k = kind(a); c = actx(a);
    exp_rd = rd_exp(a);
    for (int s = 0; s <= NSRC; s++) begin clm[s] = 0; cmp[s] = 0; end
    if (en && !we && k == 4) begin
      w = win(c);
      if (w != 0) begin clm[w] = 1; m_last[c] = w; end
    end
    if (en && we && k == 4 && d >= 1 && d <= NSRC && m_en[c][int'(d)]) cmp[int'(d)] = 1;
    np[0] = 0; nb[0] = 0;
    for (int s = 1; s <= NSRC; s++) begin
      req   = EDGE[s-1] ? (s_in[s] && !m_prev[s]) : s_in[s];
      np[s] = (m_pend[s] && !clm[s]) || (req && !m_pend[s] && (!m_busy[s] || cmp[s]));
      nb[s] = (m_busy[s] && !cmp[s]) || clm[s];
    end
    @(posedge clk); #1;
    for (int s = 0; s <= NSRC; s++) begin
      m_pend[s] = np[s]; m_busy[s] = nb[s]; m_prev[s] = s_in[s];
    end
    if (en && we) begin
      case (k)
        1: if (int'(a) / 4 != 0) m_prio[int'(a) / 4] = int'(d[2:0]);
        2: for (int s = 1; s <= NSRC; s++) m_en[c][s] = d[s];
        3: m_thr[c] = int'(d[2:0]);
        default: ;
      endcase
    end
    if (en && !we) chk(bus_rdata, exp_rd, tag);
    for (int cc = 0; cc < NCTX; cc++) chk(32'(irq_o[cc]), 32'(win(cc) != 0), tag);
    bus_en = 1'b0;
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input string tag); cyc(1, 1, a, d, tag); endtask
  task automatic rd(input logic [23:0] a, input string tag); cyc(1, 0, a, 32'd0, tag); endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 24'd0, 32'd0, tag);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int s = 0; s <= NSRC; s++) begin
      m_prio[s] = 0; m_pend[s] = 0; m_busy[s] = 0; m_prev[s] = 0; s_in[s] = 0;
    end
    for (int c = 0; c < NCTX; c++) begin
      m_thr[c] = 0; m_last[c] = 0;
      for (int s = 0; s <= NSRC; s++) m_en[c][s] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk(32'(irq_o), 32'd0, "R1");
    rd(ca(0), "R1"); chk(bus_rdata, 32'd0, "R1");
    rd(ca(1), "R1"); rd(pa(7), "R1"); rd(ea(1), "R1"); rd(ta(1), "R1");

    // R2 priority register
    wr(pa(5), 32'hFF, "R2"); rd(pa(5), "R2"); chk(bus_rdata, 32'd7, "R2");
    wr(pa(0), 32'd5, "R2");  rd(pa(0), "R2"); chk(bus_rdata, 32'd0, "R2");

    // R3 enable layout
    wr(pa(3), 2, "R3"); wr(pa(5), 6, "R3"); wr(pa(9), 6, "R3");
    wr(ea(0), (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9) | 32'd1, "R3");
    rd(ea(0), "R3"); chk(bus_rdata, (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9), "R3");
    wr(ta(0), 0, "R4");
    s_in[3] = 1; s_in[5] = 1; s_in[9] = 1;
    idle(2, "R8");
    chk(32'(irq_o), 32'd1, "R11");

    // R5 arbitration, R6 claim
    rd(ca(0), "R5"); chk(bus_rdata, 32'd5, "R5");
    rd(ca(0), "R5"); chk(bus_rdata, 32'd9, "R5");
    rd(ca(0), "R6"); chk(bus_rdata, 32'd3, "R6");
    chk(32'(irq_o[0]), 32'd0, "R6");
    rd(ca(0), "R6"); chk(bus_rdata, 32'd0, "R6");

    // R8 level re-pend
    wr(ca(0), 5, "R8"); rd(ca(0), "R8"); chk(bus_rdata, 32'd5, "R8");
    s_in[5] = 0; wr(ca(0), 5, "R8"); idle(1, "R8");
    rd(ca(0), "R8"); chk(bus_rdata, 32'd0, "R8");

    // R4 threshold
    wr(ca(0), 9, "R4"); chk(32'(irq_o[0]), 32'd1, "R4");
    wr(ta(0), 6, "R4"); chk(32'(irq_o[0]), 32'd0, "R4");
    wr(ta(0), 5, "R4"); chk(32'(irq_o[0]), 32'd1, "R4");
    wr(ta(0), 7, "R4"); chk(32'(irq_o[0]), 32'd0, "R4");
    wr(ta(0), 0, "R4"); wr(pa(9), 0, "R4"); chk(32'(irq_o[0]), 32'd0, "R4");
    wr(pa(9), 6, "R4");

    // R7 complete for a disabled source is ignored
    wr(ea(0), (32'd1 << 5) | (32'd1 << 9), "R7");
    wr(ca(0), 3, "R7");
    wr(ea(0), (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9), "R7");
    idle(1, "R7");
    rd(ca(0), "R7"); chk(bus_rdata, 32'd9, "R7");
    rd(ca(0), "R7"); chk(bus_rdata, 32'd0, "R7");
    wr(ca(0), 0, "R7"); wr(ca(0), 40, "R7");
    rd(ca(0), "R7"); chk(bus_rdata, 32'd0, "R7");
    wr(ca(0), 3, "R7"); idle(1, "R7");
    rd(ca(0), "R7"); chk(bus_rdata, 32'd3, "R7");
    s_in[3] = 0; s_in[9] = 0;
    wr(ca(0), 3, "R7"); wr(ca(0), 9, "R7");

    // R9 edge source
    wr(pa(20), 4, "R9"); wr(ea(1), 32'd1 << 20, "R9"); wr(ta(1), 0, "R9");
    s_in[20] = 1; idle(1, "R9");
    chk(32'(irq_o[1]), 32'd1, "R9");
    rd(ca(1), "R9"); chk(bus_rdata, 32'd20, "R9");
    wr(ca(1), 20, "R9"); idle(2, "R9");
    rd(ca(1), "R9"); chk(bus_rdata, 32'd0, "R9");
    s_in[20] = 0; idle(1, "R9"); s_in[20] = 1; idle(1, "R9");
    rd(ca(1), "R9"); chk(bus_rdata, 32'd20, "R9");

    // R10 edge in the cycle of the completion write
    s_in[20] = 0; idle(1, "R10");
    s_in[20] = 1; wr(ca(1), 20, "R10");
    rd(ca(1), "R10"); chk(bus_rdata, 32'd20, "R10");
    s_in[20] = 0; wr(ca(1), 20, "R10"); idle(1, "R10");

    // R11 claim by one context removes the source from the other
    wr(ea(0), (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9) | (32'd1 << 20), "R11");
    s_in[20] = 1; idle(1, "R11");
    chk(32'(irq_o), 32'd3, "R11");
    rd(ca(1), "R11"); chk(bus_rdata, 32'd20, "R11");
    chk(32'(irq_o[0]), 32'd0, "R11");
    wr(ca(0), 20, "R11"); s_in[20] = 0; idle(1, "R11");

    // constrained random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int op, c;
      logic [31:0] d;
      for (int s = 1; s <= NSRC; s++) if ($urandom % 16 == 0) s_in[s] = !s_in[s];
      op = int'($urandom % 10);
      c  = int'($urandom % NCTX);
      case (op)
        0: wr(pa(int'($urandom % 32)), $urandom, "R2");
        1: wr(ea(c), $urandom, "R3");
        2: begin
             d = ($urandom % 4 == 0) ? ($urandom % 8) : ($urandom % 3);
             wr(ta(c), d, "R4");
           end
        3, 4, 5: rd(ca(c), "R5");
        6, 7: begin
             d = ($urandom % 3 == 0) ? ($urandom % 34) : 32'(m_last[c]);
             wr(ca(c), d, "R7");
           end
        8: begin
             case ($urandom % 5)
               0: rd(pa(int'($urandom % 32)), "R2");
               1: rd(ea(c), "R3");
               2: rd(ea(c) + 24'd4, "R3");
               3: rd(ta(c), "R4");
               default: rd(ta(c) + 24'd8, "R4");
             endcase
           end
        default: idle(1, "R9");
      endcase
    end
    summary();
  end
endmodule